// File: doc/BRIEF.md
# Valid/Ready Handshake Legality Checker

This block is a passive observer for one valid/ready streaming link. It never drives the link. It watches the clock, the active-low reset, the valid and ready strobes and a data bus of configurable width, and it enforces two rules of the handshake contract. First, a sender that has offered a beat must keep offering it until the beat is accepted. Second, the beat's payload must not move while the beat waits. Each rule has its own error strobe. The strobe is high in the very cycle where the rule is broken, so a waveform or a downstream logger points straight at the offending clock.

A stalled cycle is one in which valid is high and ready is low. The checker keeps a small record of the previous cycle: whether it was stalled, and which payload was offered then. It compares the present cycle against that record. A cycle in which valid and ready are both high completes the beat, and after it the sender is free again.

Alongside the per-rule strobes, a sticky flag shows that any breach has been seen since reset. A saturating counter totals the breaches. The payload rule can be removed at elaboration for links whose data is don't-care while waiting.

Top module: `hs_legality_mon`

## Requirements
- R1: When the previous cycle was stalled (valid=1, ready=0) and valid is 0 in the present cycle, `err_drop` is 1 during the present cycle. In every other cycle it is 0.
- R2: When the previous cycle was stalled and the data bus in the present cycle differs from its value in the stalled cycle, `err_payload` is 1 during the present cycle. In every other cycle it is 0.
- R3: A cycle with valid=1 and ready=1 completes the beat. In the next cycle, valid may drop and data may change without raising either error.
- R4: While valid is 0, or while every offered beat is accepted in the cycle it is offered, data changes and valid changes raise no error.
- R5: While `rst_n` is 0, both error strobes, `any_error` and `err_count` are 0. A stall that is under way when reset asserts produces no error once reset is released.
- R6: Both strobes may be 1 in the same cycle. A stall in which valid and data are held raises neither strobe, however many cycles it lasts.
- R7: `any_error` becomes 1 in the cycle after the first cycle with a strobe high. It stays 1 until reset.
- R8: `err_count` grows, one cycle after each cycle, by the number of strobes high in that cycle (0, 1 or 2). It stops at its all-ones value and never wraps.
- R9: Checking runs in every cycle of a long stall. A payload change after several stable stalled cycles is flagged in the cycle it happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset. Checking is off while it is low |
| valid | input | 1 | Observed sender strobe |
| ready | input | 1 | Observed receiver strobe |
| data | input | DATA_W | Observed payload bus |
| err_drop | output | 1 | Early-withdrawal strobe (R1) |
| err_payload | output | 1 | Payload-moved strobe (R2) |
| any_error | output | 1 | Sticky flag: a breach has been seen since reset |
| err_count | output | CNT_W | Saturating total of breaches |

## Verification
Directed sequences separate the cases the rules must tell apart. A stall followed by withdrawal isolates the drop strobe. A stall followed by a new payload with valid held isolates the payload strobe. Withdrawal together with a new payload drives both strobes at once. A completed beat followed by an immediate change must stay silent, which separates "stalled last cycle" from "valid last cycle". Random traffic with held stalls, sporadic withdrawals and payload glitches, and both busy and idle receivers pushes the counter past saturation. Resets issued mid-stall show that stale history is discarded.

// File: rtl/hsmon_pkg.sv
package hsmon_pkg;
   // Rule indices inside the error vector
   localparam int unsigned RULE_CNT     = 2;
   localparam int unsigned RULE_DROP    = 0;
   localparam int unsigned RULE_PAYLOAD = 1;

   typedef logic [RULE_CNT-1:0] rule_vec_t;
endpackage

// File: rtl/hsmon_history.sv
// Records what the previous cycle looked like: stalled or not, and the
// payload offered while stalled.
module hsmon_history #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              ready,
   input  logic [DATA_W-1:0] data,
   output logic              stall_q,
   output logic [DATA_W-1:0] data_q
);
   logic stall_now;

   assign stall_now = valid & ~ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stall_q <= 1'b0;
         data_q  <= '0;
      end else begin
         stall_q <= stall_now;
         // payload only matters when the next cycle will compare against it
         if (stall_now) begin
            data_q <= data;
         end
      end
   end

   AST_STALL_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> (stall_q && data_q == $past(data))); // R2
endmodule

// File: rtl/hsmon_rules.sv
// Evaluates the two handshake rules for the present cycle.
module hsmon_rules
   import hsmon_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter bit          CHK_PAYLOAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              ready,
   input  logic [DATA_W-1:0] data,
   input  logic              stall_q,
   input  logic [DATA_W-1:0] data_q,
   output rule_vec_t         err
);
   logic drop_hit;
   logic pay_hit;

   assign drop_hit = rst_n & stall_q & ~valid;

   generate
      if (CHK_PAYLOAD) begin : g_pay_on
         assign pay_hit = rst_n & stall_q & (data != data_q);
      end else begin : g_pay_off
         assign pay_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      err               = '0;
      err[RULE_DROP]    = drop_hit;
      err[RULE_PAYLOAD] = pay_hit;
   end

   always_comb begin
      if (!rst_n) begin
         AST_QUIET_IN_RESET: assert (err == '0); // R5
      end
   end

   AST_DROP_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      err[RULE_DROP] |-> $past(valid && !ready)); // R1

   AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && ready) |=> (err == '0)); // R3

   AST_HELD_STALL_OK: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> ((valid && $stable(data)) -> (err == '0))); // R6
endmodule

// File: rtl/hsmon_tally.sv
// Sticky breach flag and saturating breach total.
module hsmon_tally
   import hsmon_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  rule_vec_t        err,
   output logic             any_error,
   output logic [CNT_W-1:0] err_count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W:0] inc;
   logic [CNT_W:0] sum;

   always_comb begin
      inc = '0;
      for (int i = 0; i < int'(RULE_CNT); i++) begin
         inc = inc + {{CNT_W{1'b0}}, err[i]};
      end
      sum = {1'b0, err_count} + inc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         any_error <= 1'b0;
         err_count <= '0;
      end else begin
         if (|err) begin
            any_error <= 1'b1;
         end
         if (sum > {1'b0, CNT_MAX}) begin
            err_count <= CNT_MAX;
         end else begin
            err_count <= sum[CNT_W-1:0];
         end
      end
   end

   AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      any_error |=> any_error); // R7

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (err_count == CNT_MAX) |=> (err_count == CNT_MAX)); // R8

   AST_CNT_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (err_count >= $past(err_count))); // R8
endmodule

// File: rtl/hs_legality_mon.sv
module hs_legality_mon
   import hsmon_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned CNT_W       = 16,
   parameter bit          CHK_PAYLOAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              ready,
   input  logic [DATA_W-1:0] data,
   output logic              err_drop,
   output logic              err_payload,
   output logic              any_error,
   output logic [CNT_W-1:0]  err_count
);
   generate
      if (DATA_W < 1 || DATA_W > 1024) begin : g_bad_dw
         $error("hs_legality_mon: DATA_W out of range");
      end
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cw
         $error("hs_legality_mon: CNT_W out of range");
      end
   endgenerate

   logic              stall_q;
   logic [DATA_W-1:0] data_q;
   rule_vec_t         err;

   hsmon_history #(.DATA_W(DATA_W)) u_hist (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (valid),
      .ready   (ready),
      .data    (data),
      .stall_q (stall_q),
      .data_q  (data_q)
   );

   hsmon_rules #(.DATA_W(DATA_W), .CHK_PAYLOAD(CHK_PAYLOAD)) u_rules (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (valid),
      .ready   (ready),
      .data    (data),
      .stall_q (stall_q),
      .data_q  (data_q),
      .err     (err)
   );

   hsmon_tally #(.CNT_W(CNT_W)) u_tally (
      .clk       (clk),
      .rst_n     (rst_n),
      .err       (err),
      .any_error (any_error),
      .err_count (err_count)
   );

   assign err_drop    = err[RULE_DROP];
   assign err_payload = err[RULE_PAYLOAD];

   AST_STRIKE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (err_drop || err_payload) |=> any_error); // R7
endmodule

// File: tb/test_hs_legality_mon.sv
`timescale 1ns/1ps
module test_hs_legality_mon;
   localparam int DW = 8;
   localparam int CW = 6;
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          valid = 1'b0;
   logic          ready = 1'b0;
   logic [DW-1:0] data = '0;
   logic          err_drop;
   logic          err_payload;
   logic          any_error;
   logic [CW-1:0] err_count;

   hs_legality_mon #(.DATA_W(DW), .CNT_W(CW), .CHK_PAYLOAD(1'b1)) i_hs_legality_mon (
      .clk         (clk),
      .rst_n       (rst_n),
      .valid       (valid),
      .ready       (ready),
      .data        (data),
      .err_drop    (err_drop),
      .err_payload (err_payload),
      .any_error   (any_error),
      .err_count   (err_count)
   );

   always #10 clk = ~clk;   // 50 MHz

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // reference model state, built from the requirements
   logic          m_stall = 1'b0;
   logic [DW-1:0] m_data = '0;
   logic          m_sticky = 1'b0;
   int            m_cnt = 0;

   function automatic int exp_drop(logic st, logic v);
      return (st && !v) ? 1 : 0;
   endfunction

   function automatic int exp_pay(logic st, logic [DW-1:0] old_d, logic [DW-1:0] d);
      return (st && d != old_d) ? 1 : 0;
   endfunction

   function automatic int sat_add(int c, int inc);
      return (c + inc > CMAX) ? CMAX : c + inc;
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(logic v, logic r, logic [DW-1:0] d);
      int ed;
      int ep;
      @(posedge clk);
      #1;
      valid = v;
      ready = r;
      data  = d;
      @(negedge clk);
      ed = exp_drop(m_stall, v);
      ep = exp_pay(m_stall, m_data, d);
      chk("R1 err_drop", int'(err_drop), ed);
      chk("R2 err_payload", int'(err_payload), ep);
      chk("R7 any_error", int'(any_error), int'(m_sticky));
      chk("R8 err_count", int'(err_count), m_cnt);
      m_cnt    = sat_add(m_cnt, ed + ep);
      m_sticky = m_sticky | (ed != 0) | (ep != 0);
      if (v && !r) m_data = d;
      m_stall  = v && !r;
   endtask

   // R5: hold reset several cycles with a stall on the link, expect silence
   task automatic do_reset();
      @(posedge clk);
      #1;
      rst_n = 1'b0;
      m_stall = 1'b0; m_data = '0; m_sticky = 1'b0; m_cnt = 0;
      for (int i = 0; i < 3; i++) begin
         valid = 1'b1; ready = 1'b0; data = 8'(i * 37 + 1);
         @(negedge clk);
         chk("R5 err_drop in reset", int'(err_drop), 0);
         chk("R5 err_payload in reset", int'(err_payload), 0);
         chk("R5 any_error in reset", int'(any_error), 0);
         chk("R5 err_count in reset", int'(err_count), 0);
         @(posedge clk);
         #1;
      end
      valid = 1'b0; ready = 1'b0;
      rst_n = 1'b1;
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic v;
      logic r;
      logic [DW-1:0] d;
      void'($urandom(32'd2024));
      do_reset();

      // R1: offered beat A7 waits two cycles, then valid falls
      step(1, 0, 8'hA7);
      step(1, 0, 8'hA7);
      step(0, 0, 8'hA7);   // drop flagged here
      step(0, 0, 8'h00);

      // R2: payload moves while waiting, then beat accepted; R3 afterwards free
      step(1, 0, 8'h05);
      step(1, 0, 8'h06);   // payload flagged
      step(1, 1, 8'h06);   // accepted, same data as prior cycle
      step(0, 0, 8'h99);   // R3: no error after completion
      step(1, 1, 8'h11);
      step(1, 1, 8'h12);   // R3/R4: back-to-back accepted beats

      // R6: withdrawal and new payload together
      step(1, 0, 8'h01);
      step(0, 0, 8'h02);   // both strobes

      // R4: idle with wandering data
      for (int i = 0; i < 6; i++) step(0, (i % 2) == 1, 8'(i * 53));

      // R9/R6: long held stall, then a late payload glitch
      for (int i = 0; i < 6; i++) step(1, 0, 8'h33);
      step(1, 0, 8'h34);
      step(1, 1, 8'h34);

      // R5: reset while a stall is pending, then withdraw
      step(1, 0, 8'h44);
      do_reset();
      step(0, 0, 8'h55);   // no error: history was discarded

      // random traffic, drives the counter into saturation (R8)
      for (int i = 0; i < 4000; i++) begin
         if (m_stall && ($urandom % 100) < 85) begin
            v = 1'b1;
            d = m_data;
         end else if (m_stall) begin
            v = ($urandom % 2) == 0;
            d = (($urandom % 2) == 0) ? m_data : 8'($urandom);
         end else begin
            v = ($urandom % 100) < 60;
            d = 8'($urandom);
         end
         r = ($urandom % 100) < 30;
         step(v, r, d);
      end
      step(0, 0, 8'h00);
      chk("R8 counter saturated", int'(err_count), CMAX);

      // R7: sticky flag clears only through reset
      do_reset();
      step(0, 0, 8'h00);
      chk("R7 flag cleared by reset", int'(any_error), 0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule